// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block sits behind an external divide-by-8/9 prescaler and is clocked by the prescaler output. It drives the prescaler's modulus line so that the whole chain, prescaler plus this controller, divides the RF input by 8·M + A. M is an 11-bit main count and A is a 3-bit swallow count.

Each output period spans M prescaler cycles. During the first A of those cycles the modulus line asks for divide-by-9, and during the rest it asks for divide-by-8. In the last cycle of the period the block raises a comparison pulse that lasts one prescaler cycle. The programming interface supplies a synchronous hold input. While hold is high, both counters are reloaded and both outputs stay quiet.

The programmed A and M are sampled only at a period boundary or while hold is high, so a frequency change always takes effect on a whole period. A setting with A greater than M, or with M equal to zero, cannot be built. Such a setting raises an error flag and is replaced by the nearest one that can be built.

Top module: `pulse_swallow_ctl`

## Requirements
- R1: In every cycle after a clock edge at which hold was sampled high, mod_hi and fpulse are both 0.
- R2: Hold is sampled low at edge E1, and the effective main count is Me, where Me = m_val, or 1 when m_val is 0. Then fpulse is 1 in the cycle after edge E1+Me-1, and from then on it is 1 for exactly one cycle in every Me cycles. When Me is 2 or more, fpulse is 0 in the cycle that follows a pulse.
- R3: Within each period, mod_hi is 1 for the first Ae cycles and 0 for the remaining cycles. Ae is the effective swallow count, equal to a_val, or Me when a_val is greater than Me.
- R4: Over one period, the RF cycles consumed add up to 8·Me + Ae. Each cycle with mod_hi = 1 consumes 9 RF cycles and each cycle with mod_hi = 0 consumes 8. This gives 56 for A=0, M=7, and 16383 for A=7, M=2047.
- R5: A change of a_val or m_val in the middle of a period does not alter that period's length or its swallow count. The new values govern the period that starts after the next pulse.
- R6: cfg_err is 1 exactly when a_val > m_val or m_val = 0. In that case the clamp of R2/R3 applies: with A > M, mod_hi stays high for all M cycles of each period, and with M = 0, fpulse is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| hold | input | 1 | Synchronous hold/reload from the programming interface, active high |
| a_val | input | 3 | Swallow count A |
| m_val | input | 11 | Main count M |
| mod_hi | output | 1 | Modulus control, 1 selects divide-by-9 |
| fpulse | output | 1 | Comparison pulse, one prescaler cycle wide |
| cfg_err | output | 1 | Programmed A/M pair is invalid |

## Verification
The bench aims at the boundaries of the ratio range: the smallest usable setting (A=0, M=7) and the largest (A=7, M=2047). It also covers A equal to M, where the modulus line never drops, and M equal to 1, where the pulse never falls. A design that is off by one in the main counter would show a period of M±1 and a ratio off by 8. A design that starts the swallow counter late, or reloads it at the wrong point, would get the right ratio only by luck, and the mod_hi ordering check catches that. The bench also changes A and M in mid-period, which exposes a design that reads the live inputs every cycle instead of at the boundary. Finally, it programs the invalid pairs and checks that the period is clamped and the flag is raised, rather than the counter wrapping through 2048 cycles.

// File: rtl/pulse_swallow_ctl.sv
module pulse_swallow_ctl #(
  parameter int AW = 3,
  parameter int MW = 11
) (
  input  logic          clk,
  input  logic          hold,
  input  logic [AW-1:0] a_val,
  input  logic [MW-1:0] m_val,
  output logic          mod_hi,
  output logic          fpulse,
  output logic          cfg_err
);
  localparam int CW = MW + 1;

  logic          run;
  logic [MW-1:0] m_cnt;
  logic [AW-1:0] a_cnt;
  logic [MW-1:0] m_eff;
  logic [MW-1:0] a_wide;
  logic [AW-1:0] a_eff;
  logic          reload;

  assign m_eff   = (m_val == '0) ? MW'(1) : m_val;
  assign a_wide  = MW'(a_val);
  assign a_eff   = (a_wide > m_eff) ? m_eff[AW-1:0] : a_val;
  assign cfg_err = (a_wide > m_val) | (m_val == '0);

  assign fpulse  = run & (m_cnt == '0);
  assign mod_hi  = run & (a_cnt != '0);
  assign reload  = hold | fpulse;

  always_ff @(posedge clk) begin
    run <= ~hold;
    if (reload) begin
      m_cnt <= m_eff - MW'(1);
      a_cnt <= a_eff;
    end else if (run) begin
      m_cnt <= m_cnt - MW'(1);
      if (a_cnt != '0) a_cnt <= a_cnt - AW'(1);
    end
  end

  assert_hold_quiet_R1: assert property (@(posedge clk) disable iff (hold)
    $past(hold) |-> (!fpulse && !mod_hi));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (hold)
    (fpulse && m_val > MW'(1)) |=> !fpulse);

  assert_swallow_order_R3: assert property (@(posedge clk) disable iff (hold)
    (run && !mod_hi && !fpulse) |=> !mod_hi);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (hold)
    run |-> (CW'(a_cnt) <= CW'(m_cnt) + CW'(1)));

endmodule

// File: tb/sim_pulse_swallow_ctl.sv
module sim_pulse_swallow_ctl;
  logic        clk = 1'b0;
  logic        hold = 1'b1;
  logic [2:0]  a_val = '0;
  logic [10:0] m_val = 11'd7;
  logic        mod_hi, fpulse, cfg_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pulse_swallow_ctl u0 (
    .clk(clk), .hold(hold), .a_val(a_val), .m_val(m_val),
    .mod_hi(mod_hi), .fpulse(fpulse), .cfg_err(cfg_err)
  );

  localparam logic [13:0] VEC [10] = '{
    {3'd0, 11'd7},    {3'd7, 11'd7},    {3'd3, 11'd10},  {3'd7, 11'd2047},
    {3'd0, 11'd2047}, {3'd1, 11'd1},    {3'd4, 11'd100}, {3'd7, 11'd3},
    {3'd0, 11'd0},    {3'd5, 11'd0}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog R2: act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic period(output int len, output int highs, output int rf, output int order_bad);
    bit seen_low;
    len = 0; highs = 0; rf = 0; order_bad = 0; seen_low = 0;
    do begin
      @(negedge clk);
      len++;
      if (mod_hi) begin
        highs++; rf += 9;
        if (seen_low) order_bad = 1;
      end else begin
        rf += 8; seen_low = 1;
      end
    end while (!fpulse && len < 5000);
  endtask

  task automatic start(input int a, input int m);
    @(negedge clk);
    hold = 1'b1; a_val = 3'(a); m_val = 11'(m);
    repeat (2) @(negedge clk);
    hold = 1'b0;
  endtask

  initial begin
    int len, hi, rf, ob, me, ae, er;
    repeat (3) @(negedge clk);
    check("R1 reset mod_hi", int'(mod_hi), 0);
    check("R1 reset fpulse", int'(fpulse), 0);

    for (int i = 0; i < 10; i++) begin
      int a, m;
      a = int'(VEC[i][13:11]);
      m = int'(VEC[i][10:0]);
      me = (m == 0) ? 1 : m;
      ae = (a > me) ? me : a;
      er = (a > m || m == 0) ? 1 : 0;
      start(a, m);
      check($sformatf("R6 err a=%0d m=%0d", a, m), int'(cfg_err), er);
      period(len, hi, rf, ob);
      check($sformatf("R2 first latency a=%0d m=%0d", a, m), len, me);
      check($sformatf("R3 first highs a=%0d m=%0d", a, m), hi, ae);
      for (int p = 0; p < 2; p++) begin
        period(len, hi, rf, ob);
        check($sformatf("R2 period a=%0d m=%0d", a, m), len, me);
        check($sformatf("R3 highs a=%0d m=%0d", a, m), hi, ae);
        check($sformatf("R3 order a=%0d m=%0d", a, m), ob, 0);
        check($sformatf("R4 ratio a=%0d m=%0d", a, m), rf, 8 * me + ae);
      end
    end

    start(2, 20);
    repeat (5) @(negedge clk);
    a_val = 3'd5; m_val = 11'd30;
    len = 5; hi = 0; rf = 0;
    period(me, ae, rf, ob);
    check("R5 old period kept", me + 5, 20);
    period(len, hi, rf, ob);
    check("R5 new period", len, 30);
    check("R5 new highs", hi, 5);
    check("R4 new ratio", rf, 245);

    repeat (3) @(negedge clk);
    hold = 1'b1;
    @(negedge clk);
    check("R1 hold mod_hi", int'(mod_hi), 0);
    check("R1 hold fpulse", int'(fpulse), 0);
    repeat (40) begin
      @(negedge clk);
      if (mod_hi || fpulse) check("R1 held quiet", 1, 0);
    end
    hold = 1'b0;
    period(len, hi, rf, ob);
    check("R2 after hold", len, 30);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule